// File: doc/BRIEF.md
# Trace Buffer Write Sequencer

This block moves trace words out of one queue partition and into a memory-mapped trace buffer over a write bus. It works in one of two modes. In word mode, every bus word is its own transaction. In burst mode, each transaction carries a fixed number of bytes. Burst mode waits until the partition holds a programmable fraction of a burst before it starts. If a burst starts early and the partition then runs dry, a sticky error flag is raised.

Each transaction targets an address that begins at a programmed base and steps forward by the transaction size. A programmed maximum bounds the number of transactions. When that maximum is reached, a sticky overflow flag is set and an optional one-cycle event is pulsed. The block then either wraps back to the base and keeps writing, or parks until software re-arms it. Software re-arms the block by writing a base or count register, which shows up here as a one-cycle `cfgRearm` pulse. A re-arm returns the pointer to the base and clears both flags, whether or not the written value changed.

Bus words are `DATA_W` bits, so one word is `DATA_W/8` bytes. With the default parameters a word is 8 bytes.

Top module: `trace_buf_writer`

## Requirements
- R1: With `cfgBurstEn` = 0, every transfer is one beat with `busLast` = 1, and the address steps by `DATA_W/8` bytes per transfer.
- R2: With `cfgBurstEn` = 1, `cfgBurstSize` codes 00, 01, 10 and 11 select bursts of 64, 128, 256 and 384 bytes. A burst is that many bytes divided by `DATA_W/8` beats. `busLast` is 1 on the final beat only, and the address steps by the burst size.
- R3: In burst mode, a burst starts only when `fillLevel` is at least the threshold set by `cfgThresh`. Code 00 is the whole burst, 01 is a quarter, 10 is a half and 11 is three quarters, each counted in beats. `busValid` rises on the cycle after the clock edge at which the fill first meets the threshold.
- R4: If `fillLevel` is 0 while a transfer is in progress, `burstError` sets on the next cycle and the transfer is abandoned. The address and the transaction count do not advance. `burstError` stays set until a re-arm.
- R5: The first transaction after a re-arm uses the base address. The address holds for every beat of a transaction and changes only after the final beat is accepted.
- R6: When the accepted transaction brings the count to `cfgMaxCount`, `overflow` sets on the next cycle and stays set until a re-arm. `eventOut` pulses for one cycle on that same cycle if `cfgEventEn` is 1, and does not pulse otherwise.
- R7: If `cfgWrap` is 1 when the maximum is reached, the address and count return to the base and zero, and transfers continue.
- R8: If `cfgWrap` is 0 when the maximum is reached, no further `busValid` is raised until a re-arm.
- R9: A `cfgRearm` pulse moves the pointer to `cfgBase`, zeroes the count and clears `overflow` and `burstError`, even when the configuration is unchanged. It also abandons any transfer in progress.
- R10: `busValid` is raised only while `fillLevel` is non-zero. `qPop` equals an accepted beat (`busValid` and `busReady`), and `busData` carries `qData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBase | input | ADDR_W | Byte address where the trace buffer starts |
| cfgMaxCount | input | CNT_W | Number of transactions that fill the buffer |
| cfgBurstEn | input | 1 | 1 selects burst mode, 0 selects word mode |
| cfgBurstSize | input | 2 | Burst size code |
| cfgThresh | input | 2 | Burst start threshold code |
| cfgWrap | input | 1 | Wrap to the base on full instead of stopping |
| cfgEventEn | input | 1 | Enables the full event pulse |
| cfgRearm | input | 1 | One-cycle pulse for any write to the base or count register |
| fillLevel | input | FILL_W | Words currently held in the partition |
| qData | input | DATA_W | Head word of the partition |
| qPop | output | 1 | Removes the head word from the partition |
| busValid | output | 1 | Write beat request |
| busAddr | output | ADDR_W | Start address of the current transaction |
| busData | output | DATA_W | Write beat data |
| busLast | output | 1 | Marks the final beat of a transaction |
| busReady | input | 1 | Bus accepts the beat |
| overflow | output | 1 | Sticky flag: buffer full |
| eventOut | output | 1 | One-cycle pulse when the buffer becomes full |
| burstError | output | 1 | Sticky flag: partition ran dry during a transfer |

## Verification
Each result has a fixed due cycle relative to the clock edge that causes it:

- **Start of a transfer:** after the edge at which the fill first meets the threshold, the transfer starts and `busValid` is visible one cycle later.
- **Address advance, `overflow` and `eventOut`:** these appear in the cycle after the edge that accepts the final beat.
- **`burstError`:** it appears in the cycle after the edge at which a transfer in progress finds the partition empty.
- **Re-arm:** its effects show in the cycle after the pulse.

The bench changes inputs 1 ns after each rising edge and samples 2 ns after it. A beat is therefore counted as accepted in the same cycle it is seen with `busValid` and `busReady` high. The bench's queue model removes a word only on the following cycle, just as the partition would. Each check is placed on the exact cycle derived from these counts. The one exception is the threshold test, which also checks that `busValid` is still low on the cycle before its due cycle.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  // Beat counter width; holds up to 255 beats per transaction.
  localparam int BEAT_W = 8;

  // Strobes from the control FSM to the address/count datapath.
  typedef struct packed {
    logic              rearm;
    logic              advance;
    logic [BEAT_W-1:0] beats;
  } tbw_strobe_t;

  function automatic int unsigned burstBytes(input logic [1:0] code);
    case (code)
      2'b00:   return 64;
      2'b01:   return 128;
      2'b10:   return 256;
      default: return 384;
    endcase
  endfunction

  function automatic int unsigned threshBeats(input int unsigned beats,
                                              input logic [1:0] code);
    case (code)
      2'b01:   return beats / 4;
      2'b10:   return beats / 2;
      2'b11:   return (beats * 3) / 4;
      default: return beats;
    endcase
  endfunction

endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBurstEn,
  input  logic [1:0]        cfgBurstSize,
  input  logic [1:0]        cfgThresh,
  input  logic              cfgWrap,
  input  logic              cfgEventEn,
  input  logic              cfgRearm,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic              busReady,
  input  logic              atLimit,
  output tbw_strobe_t       strobe,
  output logic              busValid,
  output logic              busLast,
  output logic              overflow,
  output logic              eventOut,
  output logic              burstError
);

  localparam int WORD_BYTES = DATA_W / 8;

  typedef enum logic {ST_IDLE, ST_XFER} state_t;

  state_t            state;
  logic [BEAT_W-1:0] beatsLeft;
  logic [BEAT_W-1:0] beatsTotal;
  logic              stopped;
  logic [BEAT_W-1:0] reqBeats;
  logic [FILL_W-1:0] startLvl;
  logic              hasData;
  logic              finish;

  always_comb begin
    reqBeats = cfgBurstEn ? BEAT_W'(burstBytes(cfgBurstSize) / WORD_BYTES) : BEAT_W'(1);
    startLvl = cfgBurstEn ? FILL_W'(threshBeats(int'(reqBeats), cfgThresh)) : FILL_W'(1);
  end

  assign hasData        = fillLevel != '0;
  assign busValid       = (state == ST_XFER) && hasData;
  assign busLast        = beatsLeft == BEAT_W'(1);
  assign finish         = busValid && busReady && busLast;
  assign strobe.rearm   = cfgRearm;
  assign strobe.advance = finish && !cfgRearm;
  assign strobe.beats   = beatsTotal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatsLeft  <= '0;
      beatsTotal <= '0;
      stopped    <= 1'b0;
      overflow   <= 1'b0;
      burstError <= 1'b0;
      eventOut   <= 1'b0;
    end else begin
      eventOut <= 1'b0;
      if (cfgRearm) begin
        state      <= ST_IDLE;
        stopped    <= 1'b0;
        overflow   <= 1'b0;
        burstError <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (!stopped && fillLevel >= startLvl) begin
              state      <= ST_XFER;
              beatsLeft  <= reqBeats;
              beatsTotal <= reqBeats;
            end
          end
          ST_XFER: begin
            if (!hasData) begin
              burstError <= 1'b1;
              state      <= ST_IDLE;
            end else if (busReady) begin
              if (busLast) begin
                state <= ST_IDLE;
                if (atLimit) begin
                  overflow <= 1'b1;
                  eventOut <= cfgEventEn;
                  stopped  <= !cfgWrap;
                end
              end else begin
                beatsLeft <= beatsLeft - BEAT_W'(1);
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/tbw_datapath.sv
module tbw_datapath
  import tbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbw_strobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgMaxCount,
  input  logic              cfgWrap,
  output logic [ADDR_W-1:0] busAddr,
  output logic              atLimit
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic [CNT_W-1:0]  txnCount;
  logic [CNT_W:0]    nextCount;
  logic [ADDR_W-1:0] step;

  assign nextCount = {1'b0, txnCount} + (CNT_W+1)'(1);
  assign atLimit   = nextCount >= {1'b0, cfgMaxCount};
  assign step      = ADDR_W'(strobe.beats) * ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      txnCount <= '0;
    end else if (strobe.rearm) begin
      busAddr  <= cfgBase;
      txnCount <= '0;
    end else if (strobe.advance) begin
      if (atLimit && cfgWrap) begin
        busAddr  <= cfgBase;
        txnCount <= '0;
      end else begin
        busAddr  <= busAddr + step;
        txnCount <= nextCount[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/trace_buf_writer.sv
module trace_buf_writer
  import tbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgMaxCount,
  input  logic              cfgBurstEn,
  input  logic [1:0]        cfgBurstSize,
  input  logic [1:0]        cfgThresh,
  input  logic              cfgWrap,
  input  logic              cfgEventEn,
  input  logic              cfgRearm,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic [DATA_W-1:0] qData,
  output logic              qPop,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              busLast,
  input  logic              busReady,
  output logic              overflow,
  output logic              eventOut,
  output logic              burstError
);

  tbw_strobe_t strobe;
  logic        atLimit;

  tbw_ctrl #(.DATA_W(DATA_W), .FILL_W(FILL_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgBurstEn(cfgBurstEn), .cfgBurstSize(cfgBurstSize), .cfgThresh(cfgThresh),
    .cfgWrap(cfgWrap), .cfgEventEn(cfgEventEn), .cfgRearm(cfgRearm),
    .fillLevel(fillLevel), .busReady(busReady), .atLimit(atLimit),
    .strobe(strobe), .busValid(busValid), .busLast(busLast),
    .overflow(overflow), .eventOut(eventOut), .burstError(burstError)
  );

  tbw_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgBase(cfgBase), .cfgMaxCount(cfgMaxCount), .cfgWrap(cfgWrap),
    .busAddr(busAddr), .atLimit(atLimit)
  );

  assign busData = qData;
  assign qPop    = busValid && busReady;

endmodule

// File: rtl/trace_buf_writer_chk.sv
module trace_buf_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int FILL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgBase,
  input logic              cfgRearm,
  input logic [FILL_W-1:0] fillLevel,
  input logic              busValid,
  input logic              busReady,
  input logic              busLast,
  input logic [ADDR_W-1:0] busAddr,
  input logic              overflow,
  input logic              eventOut,
  input logic              burstError
);

  assert_valid_has_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> fillLevel != '0);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busReady && busLast) && !cfgRearm |=> $stable(busAddr));

  assert_rearm_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgRearm |=> (busAddr == $past(cfgBase)) && !overflow && !burstError);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !cfgRearm |=> overflow);

  assert_event_with_ovf_R6: assert property (@(posedge clk) disable iff (!rstN)
    eventOut |-> overflow);

  assert_event_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    eventOut |=> !eventOut);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    burstError && !cfgRearm |=> burstError);

endmodule

bind trace_buf_writer trace_buf_writer_chk #(.ADDR_W(ADDR_W), .FILL_W(FILL_W)) i_chk (
  .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgRearm(cfgRearm),
  .fillLevel(fillLevel), .busValid(busValid), .busReady(busReady),
  .busLast(busLast), .busAddr(busAddr), .overflow(overflow),
  .eventOut(eventOut), .burstError(burstError)
);

// File: tb/test_trace_buf_writer.sv
`timescale 1ns/1ps
module test_trace_buf_writer;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 16;
  localparam int FILL_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 32'h4000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] cfgBase = BASE;
  logic [CNT_W-1:0]  cfgMaxCount = '0;
  logic cfgBurstEn = 1'b0;
  logic [1:0] cfgBurstSize = '0;
  logic [1:0] cfgThresh = '0;
  logic cfgWrap = 1'b0;
  logic cfgEventEn = 1'b0;
  logic cfgRearm = 1'b0;
  logic [FILL_W-1:0] fillLevel = '0;
  logic [DATA_W-1:0] qData = '0;
  logic qPop, busValid, busLast, overflow, eventOut, burstError;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;
  logic busReady = 1'b0;

  trace_buf_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FILL_W(FILL_W))
    i_trace_buf_writer (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int fill = 0, served = 0, cyc = 0, readyMode = 0;
  bit popPend = 1'b0, done = 1'b0;
  int gBeats, gIncr, gMax, gTxn, gBeat, gEvents;
  bit gWrap;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: update inputs 1 ns after the edge, sample 2 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    if (popPend) begin fill--; served++; end
    fillLevel = FILL_W'(fill);
    qData     = DATA_W'(served);
    busReady  = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    cfgRearm  = 1'b0;
    #1;
    popPend = qPop;
  endtask

  task automatic doRearm();
    tick();
    cfgRearm = 1'b1;
  endtask

  function automatic int bytesOf(input int code);
    return (code == 0) ? 64 : (code == 1) ? 128 : (code == 2) ? 256 : 384;
  endfunction

  task automatic checkBeat();
    longint expAddr;
    bit expLast;
    expAddr = longint'(BASE) + longint'((gWrap ? (gTxn % gMax) : gTxn) * gIncr);
    chk(busAddr == ADDR_W'(expAddr), "R5", busAddr, expAddr);
    expLast = (gBeat + 1 == gBeats);
    chk(busLast == expLast, (gBeats == 1) ? "R1" : "R2", busLast, expLast);
    chk(busData == DATA_W'(served), "R10", busData, served);
    gBeat++;
    if (busLast) begin gTxn++; gBeat = 0; end
  endtask

  task automatic watch(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      if (eventOut) gEvents++;
      if (busValid && busReady) checkBeat();
    end
  endtask

  task automatic setExpect(input int beats, input int maxc, input bit wr);
    gBeats = beats; gIncr = beats * (DATA_W / 8); gMax = maxc; gWrap = wr;
    gTxn = 0; gBeat = 0; gEvents = 0;
  endtask

  task automatic runCase(input bit be, input int sz, input int th, input bit wr,
                         input bit ev, input int maxc, input int supply, input int rdy);
    int beats, expTxn, expEv;
    beats = be ? bytesOf(sz) / (DATA_W / 8) : 1;
    cfgBurstEn = be; cfgBurstSize = 2'(sz); cfgThresh = 2'(th);
    cfgWrap = wr; cfgEventEn = ev; cfgMaxCount = CNT_W'(maxc);
    readyMode = rdy; fill = 0;
    setExpect(beats, maxc, wr);
    doRearm();
    tick();
    chk(!overflow && !burstError, "R9", overflow, 0);
    chk(busAddr == BASE, "R9", busAddr, BASE);
    fill = supply * beats;
    watch(supply * (2 * beats + 4) + 12);
    expTxn = wr ? supply : ((supply < maxc) ? supply : maxc);
    chk(gTxn == expTxn, wr ? "R7" : "R8", gTxn, expTxn);
    chk(overflow == (supply >= maxc), "R6", overflow, supply >= maxc);
    expEv = !ev ? 0 : (wr ? supply / maxc : (supply >= maxc ? 1 : 0));
    chk(gEvents == expEv, "R6", gEvents, expEv);
    chk(fill == (supply - expTxn) * beats, "R8", fill, (supply - expTxn) * beats);
    chk(!burstError, "R4", burstError, 0);
    if (!wr) chk(!busValid, "R8", busValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    chk(!busValid && !overflow && !eventOut && !burstError && !qPop, "R10", busValid, 0);

    // Burst sizes x thresholds, wrap alternating (R2, R3, R5, R6, R7, R8)
    for (int sz = 0; sz < 4; sz++)
      for (int th = 0; th < 4; th++)
        runCase(1'b1, sz, th, th[0], 1'b1, 3, 5, sz % 2);

    // Word mode, no wrap, then re-arm with unchanged values (R1, R8, R9)
    runCase(1'b0, 0, 0, 1'b0, 1'b1, 4, 6, 1);
    doRearm();
    tick();
    chk(!overflow, "R9", overflow, 0);
    chk(busAddr == BASE, "R9", busAddr, BASE);
    setExpect(1, 4, 1'b0);
    watch(20);
    chk(gTxn == 2, "R9", gTxn, 2);
    chk(fill == 0, "R9", fill, 0);

    // Word mode with wrap and event disabled (R1, R6, R7)
    runCase(1'b0, 0, 0, 1'b1, 1'b0, 2, 5, 0);

    // Threshold start timing, 64-byte bursts of 8 beats (R3, R4)
    for (int th = 0; th < 4; th++) begin
      int t;
      t = (th == 0) ? 8 : (th == 1) ? 2 : (th == 2) ? 4 : 6;
      cfgBurstEn = 1'b1; cfgBurstSize = 2'b00; cfgThresh = 2'(th);
      cfgWrap = 1'b0; cfgMaxCount = 16'd100; readyMode = 0; fill = 0;
      doRearm();
      tick();
      fill = t - 1;
      begin
        bit seen = 1'b0;
        for (int i = 0; i < 10; i++) begin tick(); if (busValid) seen = 1'b1; end
        chk(!seen, "R3", seen, 0);
      end
      fill = t;
      tick();
      chk(!busValid, "R3", busValid, 0);
      tick();
      chk(busValid, "R3", busValid, 1);
      for (int i = 0; i < 30; i++) tick();
      chk(burstError == (th != 0), "R4", burstError, th != 0);
      chk(fill == 0, "R3", fill, 0);
    end

    // Early burst runs dry: error, no advance, sticky (R4)
    cfgBurstEn = 1'b1; cfgBurstSize = 2'b00; cfgThresh = 2'b01;
    cfgWrap = 1'b0; cfgEventEn = 1'b0; cfgMaxCount = 16'd3; readyMode = 0; fill = 0;
    doRearm();
    tick();
    setExpect(8, 3, 1'b0);
    fill = 5;
    watch(40);
    chk(burstError, "R4", burstError, 1);
    chk(gTxn == 0, "R4", gTxn, 0);
    gBeat = 0;
    fill = 8;
    watch(30);
    chk(gTxn == 1, "R4", gTxn, 1);
    chk(busAddr == BASE + 64, "R4", busAddr, BASE + 64);
    chk(burstError, "R4", burstError, 1);
    doRearm();
    tick();
    chk(!burstError, "R9", burstError, 0);
    chk(busAddr == BASE, "R9", busAddr, BASE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule